// File: doc/BRIEF.md
# Priority Throttle Request Arbiter

This block combines several throttle requests into one final throttle setting. There are three request sources. Source 0 is the heavy thermal event, source 1 is the light thermal event and source 2 is the overcurrent event. Each source holds three configuration values: a priority, a CPU throttle depth given as a percentage, and a GPU throttle level given as a 2-bit code.

In every cycle the arbiter considers the sources whose request line is high and whose priority is not zero. The active source with the largest priority wins. The block then presents that source's CPU percentage, its GPU level, its index and a valid flag, all from an output register. Configuration values are loaded through a single-cycle write strobe that carries a source index, a field code and a data byte.

Top module: `thr_arb`

## Requirements
- R1: When exactly one source is requesting and its priority is non-zero, the outputs carry that source's stored CPU percentage and GPU level. `valid_o` is 1 and `win_idx_o` equals the source index (0 heavy, 1 light, 2 overcurrent).
- R2: A priority write (field code 0) stores the data byte, saturated to 100. A stored priority of 0 removes the source from arbitration, even while its request line is high.
- R3: Among the requesting sources with non-zero priority, the one with the numerically largest priority provides all outputs.
- R4: A CPU depth write (field code 1) stores the data byte, saturated to 100. `cpu_pct_o` never exceeds 100.
- R5: A GPU level write (field code 2) stores the two least significant data bits. The code meanings are 0 none, 1 low, 2 medium, 3 high, and `gpu_lvl_o` reproduces the stored code unchanged.
- R6: When no source is both requesting and enabled, `valid_o` is 0 and `cpu_pct_o`, `gpu_lvl_o` and `win_idx_o` are all 0.
- R7: When two or more winning candidates share the same priority, the lowest source index wins.
- R8: A change of `req_i` appears at the outputs after the next rising clock edge, and not before it. A configuration write appears at the outputs after the second rising edge that follows the edge where the strobe was sampled.
- R9: A write with field code 3, or with a source index of 3 or more, changes no stored value.
- R10: After reset all priorities, depths and levels are 0. The outputs are then 0 with `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Throttle request per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_src_i | input | IDX_W | Source index of the write |
| cfg_fld_i | input | 2 | Field code: 0 priority, 1 CPU depth, 2 GPU level, 3 reserved |
| cfg_wdata_i | input | DATA_W | Write data |
| cpu_pct_o | output | PCT_W | Final CPU throttle percentage |
| gpu_lvl_o | output | LVL_W | Final GPU throttle level |
| valid_o | output | 1 | A source won arbitration |
| win_idx_o | output | IDX_W | Index of the winning source |

## Verification
The bench builds the block with its default parameters: three sources, an 8-bit data path and caps of 100. With an 8-bit write byte, values above the cap can be written, so both saturation paths can be exercised. With a 2-bit source index, index 3 is reachable, so a write to a source that does not exist can be tested. A priority of 120, which would otherwise beat 100, shows whether the cap is enforced: after saturation it ties with the heavy source and loses on index.

// File: rtl/thr_arb_pkg.sv
package thr_arb_pkg;
  typedef enum logic [1:0] {
    FLD_PRIO = 2'd0,
    FLD_CPU  = 2'd1,
    FLD_GPU  = 2'd2,
    FLD_RSVD = 2'd3
  } cfg_fld_e;
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
  import thr_arb_pkg::*;
#(
  parameter int N_SRC    = 3,
  parameter int IDX_W    = 2,
  parameter int DATA_W   = 8,
  parameter int PRIO_MAX = 100,
  parameter int PRIO_W   = 7,
  parameter int PCT_MAX  = 100,
  parameter int PCT_W    = 7,
  parameter int LVL_W    = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               src_i,
  input  logic [1:0]                     fld_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [N_SRC-1:0][PRIO_W-1:0]   prio_o,
  output logic [N_SRC-1:0][PCT_W-1:0]    pct_o,
  output logic [N_SRC-1:0][LVL_W-1:0]    lvl_o
);
  cfg_fld_e fld;
  assign fld = cfg_fld_e'(fld_i);

  // saturate once, shared by all sources
  logic [PRIO_W-1:0] prio_sat;
  logic [PCT_W-1:0]  pct_sat;
  assign prio_sat = (wdata_i > DATA_W'(PRIO_MAX)) ? PRIO_W'(PRIO_MAX) : wdata_i[PRIO_W-1:0];
  assign pct_sat  = (wdata_i > DATA_W'(PCT_MAX))  ? PCT_W'(PCT_MAX)   : wdata_i[PCT_W-1:0];

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic hit;
    assign hit = we_i && (src_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[g] <= '0;
        pct_o[g]  <= '0;
        lvl_o[g]  <= '0;
      end else if (hit) begin
        case (fld)
          FLD_PRIO: prio_o[g] <= prio_sat;
          FLD_CPU:  pct_o[g]  <= pct_sat;
          FLD_GPU:  lvl_o[g]  <= wdata_i[LVL_W-1:0];
          default:  ;
        endcase
      end
    end

    AST_PRIO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prio_o[g] <= PRIO_W'(PRIO_MAX)); // R2
    AST_PCT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pct_o[g] <= PCT_W'(PCT_MAX)); // R4
    AST_RSVD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && fld_i == 2'd3) |=> ($stable(prio_o[g]) && $stable(pct_o[g]) && $stable(lvl_o[g]))); // R9
  end

  if (N_SRC < (1 << IDX_W)) begin : g_oob
    AST_OOB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && src_i >= IDX_W'(N_SRC)) |=> ($stable(prio_o) && $stable(pct_o) && $stable(lvl_o))); // R9
  end
endmodule

// File: rtl/thr_prio_pick.sv
module thr_prio_pick #(
  parameter int N_SRC  = 3,
  parameter int IDX_W  = 2,
  parameter int PRIO_W = 7,
  parameter int PCT_W  = 7,
  parameter int LVL_W  = 2
) (
  input  logic [N_SRC-1:0]               req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0]   prio_i,
  input  logic [N_SRC-1:0][PCT_W-1:0]    pct_i,
  input  logic [N_SRC-1:0][LVL_W-1:0]    lvl_i,
  output logic                           valid_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [PCT_W-1:0]               pct_o,
  output logic [LVL_W-1:0]               lvl_o
);
  logic [PRIO_W-1:0] stg_p [N_SRC+1];
  logic [IDX_W-1:0]  stg_i [N_SRC+1];
  logic [PCT_W-1:0]  stg_c [N_SRC+1];
  logic [LVL_W-1:0]  stg_l [N_SRC+1];
  logic              stg_v [N_SRC+1];

  assign stg_p[0] = '0;
  assign stg_i[0] = '0;
  assign stg_c[0] = '0;
  assign stg_l[0] = '0;
  assign stg_v[0] = 1'b0;

  // strict '>' keeps the lower index on ties and rejects priority 0
  for (genvar g = 0; g < N_SRC; g++) begin : g_stg
    logic take;
    assign take = req_i[g] && (prio_i[g] > stg_p[g]);
    assign stg_p[g+1] = take ? prio_i[g]   : stg_p[g];
    assign stg_i[g+1] = take ? IDX_W'(g)   : stg_i[g];
    assign stg_c[g+1] = take ? pct_i[g]    : stg_c[g];
    assign stg_l[g+1] = take ? lvl_i[g]    : stg_l[g];
    assign stg_v[g+1] = take | stg_v[g];
  end

  assign valid_o = stg_v[N_SRC];
  assign idx_o   = stg_i[N_SRC];
  assign pct_o   = stg_c[N_SRC];
  assign lvl_o   = stg_l[N_SRC];

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      if (valid_o && req_i[i]) begin
        AST_WIN_MAX: assert (prio_i[i] <= stg_p[N_SRC]); // R3
        if (prio_i[i] == stg_p[N_SRC]) begin
          AST_TIE_LOW: assert (IDX_W'(i) >= idx_o); // R7
        end
      end
    end
  end
endmodule

// File: rtl/thr_arb.sv
module thr_arb #(
  parameter int N_SRC    = 3,
  parameter int DATA_W   = 8,
  parameter int PRIO_MAX = 100,
  parameter int PCT_MAX  = 100,
  parameter int LVL_W    = 2,
  localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int PRIO_W  = $clog2(PRIO_MAX + 1),
  localparam int PCT_W   = $clog2(PCT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_src_i,
  input  logic [1:0]        cfg_fld_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [PCT_W-1:0]  cpu_pct_o,
  output logic [LVL_W-1:0]  gpu_lvl_o,
  output logic              valid_o,
  output logic [IDX_W-1:0]  win_idx_o
);
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [N_SRC-1:0][PCT_W-1:0]  pct;
  logic [N_SRC-1:0][LVL_W-1:0]  lvl;

  logic             pk_valid;
  logic [IDX_W-1:0] pk_idx;
  logic [PCT_W-1:0] pk_pct;
  logic [LVL_W-1:0] pk_lvl;

  thr_cfg_regs #(
    .N_SRC(N_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W),
    .PRIO_MAX(PRIO_MAX), .PRIO_W(PRIO_W),
    .PCT_MAX(PCT_MAX), .PCT_W(PCT_W), .LVL_W(LVL_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .src_i   (cfg_src_i),
    .fld_i   (cfg_fld_i),
    .wdata_i (cfg_wdata_i),
    .prio_o  (prio),
    .pct_o   (pct),
    .lvl_o   (lvl)
  );

  thr_prio_pick #(
    .N_SRC(N_SRC), .IDX_W(IDX_W), .PRIO_W(PRIO_W),
    .PCT_W(PCT_W), .LVL_W(LVL_W)
  ) u_pick (
    .req_i   (req_i),
    .prio_i  (prio),
    .pct_i   (pct),
    .lvl_i   (lvl),
    .valid_o (pk_valid),
    .idx_o   (pk_idx),
    .pct_o   (pk_pct),
    .lvl_o   (pk_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      win_idx_o <= '0;
      cpu_pct_o <= '0;
      gpu_lvl_o <= '0;
    end else begin
      valid_o   <= pk_valid;
      win_idx_o <= pk_idx;
      cpu_pct_o <= pk_pct;
      gpu_lvl_o <= pk_lvl;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (cpu_pct_o == '0 && gpu_lvl_o == '0 && win_idx_o == '0)); // R6
  AST_WIN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((($past(req_i) >> win_idx_o) & N_SRC'(1)) != '0)); // R8
  AST_OUT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_pct_o <= PCT_W'(PCT_MAX)); // R4
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_idx_o < IDX_W'(N_SRC)); // R1
endmodule

// File: tb/thr_arb_bench.sv
module thr_arb_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0;
  logic       we = 1'b0;
  logic [1:0] src = '0;
  logic [1:0] fld = '0;
  logic [7:0] wdata = '0;
  logic [6:0] cpu_pct;
  logic [1:0] gpu_lvl;
  logic       valid;
  logic [1:0] win_idx;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  thr_arb u_thr_arb (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .cfg_we_i(we), .cfg_src_i(src), .cfg_fld_i(fld), .cfg_wdata_i(wdata),
    .cpu_pct_o(cpu_pct), .gpu_lvl_o(gpu_lvl), .valid_o(valid), .win_idx_o(win_idx)
  );

  task automatic chk(input int e_pct, input int e_lvl, input int e_v, input int e_idx,
                     input string tag);
    checks++;
    if (cpu_pct != 7'(e_pct) || gpu_lvl != 2'(e_lvl) || valid != 1'(e_v) || win_idx != 2'(e_idx)) begin
      errors++;
      $display("FAIL %s: act pct=%0d lvl=%0d v=%0d idx=%0d exp pct=%0d lvl=%0d v=%0d idx=%0d",
               tag, cpu_pct, gpu_lvl, valid, win_idx, e_pct, e_lvl, e_v, e_idx);
    end
  endtask

  // returns at the negedge after the edge that sampled the strobe
  task automatic wr(input int s, input int f, input int d);
    src = 2'(s); fld = 2'(f); wdata = 8'(d); we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_req(input logic [2:0] r);
    req = r;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    chk(0, 0, 0, 0, "R10 reset state");
    set_req(3'b111);
    chk(0, 0, 0, 0, "R10 all priorities zero after reset");
    set_req(3'b000);
  endtask

  task automatic t_config_timing;
    wr(0, 1, 85); wr(0, 2, 3);
    req = 3'b001;
    @(posedge clk); @(negedge clk);
    chk(0, 0, 0, 0, "R2 heavy disabled with priority 0");
    wr(0, 0, 100);
    chk(0, 0, 0, 0, "R8 write not visible after first edge");
    @(posedge clk); @(negedge clk);
    chk(85, 3, 1, 0, "R8 write visible after second edge");
    wr(1, 0, 80); wr(1, 1, 50); wr(1, 2, 1);
    wr(2, 0, 50); wr(2, 1, 75); wr(2, 2, 8'hFE);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_single;
    set_req(3'b010);
    chk(50, 1, 1, 1, "R1 light alone");
    set_req(3'b100);
    chk(75, 2, 1, 2, "R5 overcurrent alone, level from low bits");
    set_req(3'b001);
    chk(85, 3, 1, 0, "R1 heavy alone");
  endtask

  task automatic t_priority;
    set_req(3'b111);
    chk(85, 3, 1, 0, "R3 all active, heavy wins");
    set_req(3'b110);
    chk(50, 1, 1, 1, "R3 light beats overcurrent");
    req = 3'b100;
    #1;
    chk(50, 1, 1, 1, "R8 output held before edge");
    @(posedge clk); @(negedge clk);
    chk(75, 2, 1, 2, "R8 output after edge");
  endtask

  task automatic t_saturate;
    wr(2, 0, 120);
    req = 3'b110;
    @(posedge clk); @(negedge clk);
    chk(75, 2, 1, 2, "R2 overcurrent 100 beats light 80");
    set_req(3'b101);
    chk(85, 3, 1, 0, "R7 tie at 100, heavy index wins; R2 cap");
    wr(1, 1, 200);
    req = 3'b010;
    @(posedge clk); @(negedge clk);
    chk(100, 1, 1, 1, "R4 cpu depth saturates at 100");
  endtask

  task automatic t_disable_invalid;
    wr(1, 3, 5);
    wr(3, 0, 100);
    wr(3, 1, 7);
    @(posedge clk); @(negedge clk);
    chk(100, 1, 1, 1, "R9 reserved field and bad source ignored");
    wr(0, 0, 0);
    req = 3'b001;
    @(posedge clk); @(negedge clk);
    chk(0, 0, 0, 0, "R2 priority 0 removes heavy");
    set_req(3'b011);
    chk(100, 1, 1, 1, "R2 disabled heavy loses to light");
    set_req(3'b000);
    chk(0, 0, 0, 0, "R6 no request gives zeros");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired: act running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset_pre();
    t_reset;
    t_config_timing;
    t_single;
    t_priority;
    t_saturate;
    t_disable_invalid;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic t_reset_pre;
    chk(0, 0, 0, 0, "R10 outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask
endmodule